// File: doc/BRIEF.md
# DMA Channel Register Bank and Interrupt Control

This block is the software-visible control face of a multi-channel DMA controller. A simple word-wide register bus reaches a small global region (a control word, two interrupt mask words and two interrupt source words) and a run of equal-sized per-channel windows. Each window holds a status/control word plus size, source and destination address, address mask, descriptor pointer and software pointer words. The transfer engines sit outside the block. They receive an enable level together with start and abort pulses from it, and they return done, error and chunk-complete events to it.

Some reads change state. Reading a channel control word clears its sticky event bits. Reading the first interrupt source word empties it, which drops the interrupt line. The channel enable bit acts on edges: setting it launches the channel, and clearing it while the channel is busy cancels the transfer. A done or error event raises the interrupt only when both the per-channel enable bit and the global mask bit allow it. The raising channel then replaces the content of the source word with its one-hot code.

Top module: `dma_rf_top`

## Requirements
- R1: After reset every control, size, address, descriptor, pointer, mask and source word reads 0. The exception is both address-mask words of every channel, which read 0xFFFFFFFC. The interrupt line and all enable levels are 0.
- R2: Offsets below 0x20 select the global words: 0x00 control, 0x04 mask A, 0x08 mask B, 0x0C source A, 0x10 source B. Channel n occupies 0x20+n*0x20, with words at +0x00 control, +0x04 size, +0x08 source address, +0x0C source mask, +0x10 destination address, +0x14 destination mask, +0x18 descriptor, +0x1C software pointer. Read data and its valid flag appear in the cycle after the request.
- R3: Global offsets 0x14 to 0x1C, channel numbers of NUM_CH or more, and any address whose two low bits are nonzero are unmapped. They read 0, and writes to them change no word and produce no pulse.
- R4: A write to a channel control word changes only bit 0 (enable), bit 5 (done interrupt enable), bit 6 (error interrupt enable) and bits 15:10 (engine options). Bit 2 (busy), bit 3 (done), bit 4 (error), bit 7 (done interrupt), bit 8 (error interrupt), bit 9 (chunk done) and bits 31:16 are left as they were.
- R5: A read of a channel control word returns its value from before the read and then clears bits 4, 7, 8 and 9. Bit 3 is kept.
- R6: A control word write with bit 0 set, while bit 0 is clear, produces a one-cycle start pulse for that channel and sets busy. A write with bit 0 set while it is already set produces no pulse.
- R7: A control word write with bit 0 clear, while the channel is busy, produces a one-cycle abort pulse and clears busy.
- R8: A done event sets bit 3, and an error event sets bit 4. Either event clears enable and busy. A chunk event sets bit 9.
- R9: A done (or error) event sets bit 7 (or bit 8) and raises the interrupt only if bit 5 (or bit 6) is set and the channel's bit in mask A is set.
- R10: A raised interrupt overwrites source A with the one-hot code of the channel, bit n for channel n. If several channels raise in the same cycle, the lowest-numbered one is recorded.
- R11: Reading source A returns its value and then zeroes it. The interrupt line is high exactly while source A is nonzero. Source B does not clear on read.
- R12: An event that lands in the same cycle as the clearing read of a control word or of source A survives the clear and remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High the cycle after a read request |
| evt_done | input | NUM_CH | Transfer-complete event per channel |
| evt_err | input | NUM_CH | Transfer-error event per channel |
| evt_chunk | input | NUM_CH | Chunk-complete event per channel |
| ch_start | output | NUM_CH | One-cycle launch pulse per channel |
| ch_abort | output | NUM_CH | One-cycle cancel pulse per channel |
| ch_enable | output | NUM_CH | Current enable bit per channel |
| irq | output | 1 | Interrupt line |

## Verification
The assertions check the following on every cycle:
- start pulses only follow a clear enable bit;
- an abort leaves busy low;
- a quiet control read empties the sticky bits;
- the read-only bits survive control writes;
- an interrupt bit only rises when both gates were open;
- source A is one-hot after a raise, and its read empties it;
- source B never changes without a write.

Some behaviours can only be shown by the bench's scenarios:
- the exact map of offsets and the unmapped holes;
- the reset values;
- the lowest-channel choice when two channels raise together;
- replacement rather than accumulation of source A;
- events surviving a same-cycle clearing read.

// File: rtl/dma_rf_pkg.sv
`timescale 1ns/1ps
package dma_rf_pkg;

    localparam int DW        = 32;
    localparam int WIN_SHIFT = 5;

    // global word indices (address bits 4:2)
    localparam logic [2:0] G_CTRL   = 3'd0;
    localparam logic [2:0] G_MASK_A = 3'd1;
    localparam logic [2:0] G_MASK_B = 3'd2;
    localparam logic [2:0] G_SRC_A  = 3'd3;
    localparam logic [2:0] G_SRC_B  = 3'd4;

    // channel word indices
    localparam logic [2:0] C_CSR   = 3'd0;
    localparam logic [2:0] C_SZ    = 3'd1;
    localparam logic [2:0] C_SRC   = 3'd2;
    localparam logic [2:0] C_SRCM  = 3'd3;
    localparam logic [2:0] C_DST   = 3'd4;
    localparam logic [2:0] C_DSTM  = 3'd5;
    localparam logic [2:0] C_DESC  = 3'd6;
    localparam logic [2:0] C_SWPTR = 3'd7;

    // control word bit positions
    localparam int B_EN       = 0;
    localparam int B_BUSY     = 2;
    localparam int B_DONE     = 3;
    localparam int B_ERR      = 4;
    localparam int B_IE_DONE  = 5;
    localparam int B_IE_ERR   = 6;
    localparam int B_INT_DONE = 7;
    localparam int B_INT_ERR  = 8;
    localparam int B_CHUNK    = 9;

    localparam logic [DW-1:0] CSR_WMASK = 32'h0000_FC61;
    localparam logic [DW-1:0] CSR_COR   = 32'h0000_0390;
    localparam logic [DW-1:0] AM_RESET  = 32'hFFFF_FFFC;

    typedef struct packed {
        logic [DW-1:0] csr;
        logic [DW-1:0] sz;
        logic [DW-1:0] src;
        logic [DW-1:0] srcm;
        logic [DW-1:0] dst;
        logic [DW-1:0] dstm;
        logic [DW-1:0] desc;
        logic [DW-1:0] swptr;
    } ch_regs_t;

    typedef struct packed {
        logic       glob_hit;
        logic       ch_hit;
        logic [2:0] idx;
    } dec_t;

    function automatic logic [DW-1:0] ch_word(input ch_regs_t r, input logic [2:0] idx);
        case (idx)
            C_CSR:   ch_word = r.csr;
            C_SZ:    ch_word = r.sz;
            C_SRC:   ch_word = r.src;
            C_SRCM:  ch_word = r.srcm;
            C_DST:   ch_word = r.dst;
            C_DSTM:  ch_word = r.dstm;
            C_DESC:  ch_word = r.desc;
            default: ch_word = r.swptr;
        endcase
    endfunction

endpackage

// File: rtl/dma_rf_decode.sv
`timescale 1ns/1ps
module dma_rf_decode
    import dma_rf_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int NUM_CH  = 4,
    parameter int CH_BASE = 32,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic [CH_W-1:0]   ch_num
);
    localparam int HI_W = ADDR_W - WIN_SHIFT;

    logic              below;
    logic [ADDR_W-1:0] off;
    logic [HI_W-1:0]   win;

    always_comb begin
        below = addr < ADDR_W'(CH_BASE);
        off   = addr - ADDR_W'(CH_BASE);
        win   = off[ADDR_W-1:WIN_SHIFT];
        dec.glob_hit = below && (addr[1:0] == 2'b00) && (addr[4:2] <= G_SRC_B);
        dec.ch_hit   = !below && (off[1:0] == 2'b00) && (win < HI_W'(NUM_CH));
        dec.idx      = below ? addr[4:2] : off[4:2];
        ch_num       = win[CH_W-1:0];
    end

endmodule

// File: rtl/dma_rf_channel.sv
`timescale 1ns/1ps
module dma_rf_channel
    import dma_rf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_idx,
    input  logic [DW-1:0] wdata,
    input  logic          rd_csr,
    input  logic          mask_bit,
    input  logic          evt_done,
    input  logic          evt_err,
    input  logic          evt_chunk,
    output ch_regs_t      regs,
    output logic          start_o,
    output logic          abort_o,
    output logic          raise_o
);
    ch_regs_t regs_n;
    logic     start_c, abort_c, gate_done, gate_err;

    always_comb begin
        gate_done = evt_done && regs.csr[B_IE_DONE] && mask_bit;
        gate_err  = evt_err  && regs.csr[B_IE_ERR]  && mask_bit;
        raise_o   = gate_done || gate_err;
        start_c   = wr_en && (wr_idx == C_CSR) && wdata[B_EN] && !regs.csr[B_EN];
        abort_c   = wr_en && (wr_idx == C_CSR) && !wdata[B_EN] && regs.csr[B_BUSY];

        regs_n = regs;
        if (wr_en) begin
            case (wr_idx)
                C_CSR:   regs_n.csr   = (regs.csr & ~CSR_WMASK) | (wdata & CSR_WMASK);
                C_SZ:    regs_n.sz    = wdata;
                C_SRC:   regs_n.src   = wdata;
                C_SRCM:  regs_n.srcm  = wdata;
                C_DST:   regs_n.dst   = wdata;
                C_DSTM:  regs_n.dstm  = wdata;
                C_DESC:  regs_n.desc  = wdata;
                default: regs_n.swptr = wdata;
            endcase
        end
        if (rd_csr)  regs_n.csr = regs_n.csr & ~CSR_COR;
        if (start_c) regs_n.csr[B_BUSY] = 1'b1;
        if (abort_c) regs_n.csr[B_BUSY] = 1'b0;
        // engine events are applied last so they win over clears
        if (evt_chunk) regs_n.csr[B_CHUNK] = 1'b1;
        if (evt_done) begin
            regs_n.csr[B_DONE] = 1'b1;
            regs_n.csr[B_EN]   = 1'b0;
            regs_n.csr[B_BUSY] = 1'b0;
            if (gate_done) regs_n.csr[B_INT_DONE] = 1'b1;
        end
        if (evt_err) begin
            regs_n.csr[B_ERR]  = 1'b1;
            regs_n.csr[B_EN]   = 1'b0;
            regs_n.csr[B_BUSY] = 1'b0;
            if (gate_err) regs_n.csr[B_INT_ERR] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs      <= '0;
            regs.srcm <= AM_RESET;
            regs.dstm <= AM_RESET;
            start_o   <= 1'b0;
            abort_o   <= 1'b0;
        end else begin
            regs    <= regs_n;
            start_o <= start_c;
            abort_o <= abort_c;
        end
    end

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        start_o |-> !$past(regs.csr[B_EN])); // R6
    AST_ABORT_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> !regs.csr[B_BUSY]); // R7
    AST_QUIET_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_csr && !evt_done && !evt_err && !evt_chunk) |=> ((regs.csr & CSR_COR) == '0)); // R5
    AST_DONE_BIT_HELD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == C_CSR && !evt_done) |=> $stable(regs.csr[B_DONE])); // R4
    AST_INT_DONE_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(regs.csr[B_INT_DONE]) |-> $past(mask_bit && regs.csr[B_IE_DONE])); // R9
    AST_INT_ERR_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(regs.csr[B_INT_ERR]) |-> $past(mask_bit && regs.csr[B_IE_ERR])); // R9

endmodule

// File: rtl/dma_rf_global.sv
`timescale 1ns/1ps
module dma_rf_global
    import dma_rf_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  logic [DW-1:0]     wdata,
    input  logic              rd_src_a,
    input  logic [NUM_CH-1:0] raise,
    output logic [DW-1:0]     ctrl,
    output logic [DW-1:0]     mask_a,
    output logic [DW-1:0]     mask_b,
    output logic [DW-1:0]     src_a,
    output logic [DW-1:0]     src_b,
    output logic              irq
);
    logic [NUM_CH-1:0] first;
    logic [DW-1:0]     src_a_n;

    always_comb begin
        first   = raise & (~raise + NUM_CH'(1));
        src_a_n = src_a;
        if (wr_en && wr_idx == G_SRC_A) src_a_n = wdata;
        else if (rd_src_a)              src_a_n = '0;
        if (|raise)                     src_a_n = DW'(first);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            mask_a <= '0;
            mask_b <= '0;
            src_a  <= '0;
            src_b  <= '0;
        end else begin
            src_a <= src_a_n;
            if (wr_en) begin
                case (wr_idx)
                    G_CTRL:   ctrl   <= wdata;
                    G_MASK_A: mask_a <= wdata;
                    G_MASK_B: mask_b <= wdata;
                    G_SRC_B:  src_b  <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    assign irq = |src_a;

    AST_RAISE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (|raise) |=> $onehot(src_a)); // R10
    AST_SRC_A_EMPTIED: assert property (@(posedge clk) disable iff (rst)
        (rd_src_a && !(|raise)) |=> (src_a == '0 && !irq)); // R11
    AST_SRC_B_KEPT: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_idx == G_SRC_B) |=> $stable(src_b)); // R11

endmodule

// File: rtl/dma_rf_top.sv
`timescale 1ns/1ps
module dma_rf_top
    import dma_rf_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int NUM_CH  = 4,
    parameter int CH_BASE = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_rvalid,
    input  logic [NUM_CH-1:0] evt_done,
    input  logic [NUM_CH-1:0] evt_err,
    input  logic [NUM_CH-1:0] evt_chunk,
    output logic [NUM_CH-1:0] ch_start,
    output logic [NUM_CH-1:0] ch_abort,
    output logic [NUM_CH-1:0] ch_enable,
    output logic              irq
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    dec_t              dec;
    logic [CH_W-1:0]   ch_num;
    logic              wr_go, rd_go;
    ch_regs_t          ch_regs [NUM_CH];
    logic [NUM_CH-1:0] raise;
    logic [DW-1:0]     g_ctrl, g_mask_a, g_mask_b, g_src_a, g_src_b;
    logic [DW-1:0]     rdata_c;

    assign wr_go = bus_valid && bus_write;
    assign rd_go = bus_valid && !bus_write;

    dma_rf_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_BASE(CH_BASE)) u_dec (
        .addr(bus_addr), .dec(dec), .ch_num(ch_num)
    );

    dma_rf_global #(.NUM_CH(NUM_CH)) u_glob (
        .clk(clk), .rst(rst),
        .wr_en(wr_go && dec.glob_hit), .wr_idx(dec.idx), .wdata(bus_wdata),
        .rd_src_a(rd_go && dec.glob_hit && dec.idx == G_SRC_A),
        .raise(raise),
        .ctrl(g_ctrl), .mask_a(g_mask_a), .mask_b(g_mask_b),
        .src_a(g_src_a), .src_b(g_src_b), .irq(irq)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = dec.ch_hit && (ch_num == CH_W'(i));
        dma_rf_channel u_ch (
            .clk(clk), .rst(rst),
            .wr_en(wr_go && sel), .wr_idx(dec.idx), .wdata(bus_wdata),
            .rd_csr(rd_go && sel && dec.idx == C_CSR),
            .mask_bit(g_mask_a[i]),
            .evt_done(evt_done[i]), .evt_err(evt_err[i]), .evt_chunk(evt_chunk[i]),
            .regs(ch_regs[i]),
            .start_o(ch_start[i]), .abort_o(ch_abort[i]), .raise_o(raise[i])
        );
        assign ch_enable[i] = ch_regs[i].csr[B_EN];
    end

    always_comb begin
        rdata_c = '0;
        if (dec.glob_hit) begin
            case (dec.idx)
                G_CTRL:   rdata_c = g_ctrl;
                G_MASK_A: rdata_c = g_mask_a;
                G_MASK_B: rdata_c = g_mask_b;
                G_SRC_A:  rdata_c = g_src_a;
                default:  rdata_c = g_src_b;
            endcase
        end else if (dec.ch_hit) begin
            for (int k = 0; k < NUM_CH; k++)
                if (ch_num == CH_W'(k)) rdata_c = ch_word(ch_regs[k], dec.idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_go;
            bus_rdata  <= rd_go ? rdata_c : '0;
        end
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> bus_rvalid); // R2
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> !bus_rvalid); // R2

endmodule

// File: tb/tb_dma_rf_top.sv
`timescale 1ns/1ps
module tb_dma_rf_top;
    localparam int ADDR_W = 10;
    localparam int NUM_CH = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0, bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0, bus_rdata;
    logic              bus_rvalid;
    logic [NUM_CH-1:0] evt_done = '0, evt_err = '0, evt_chunk = '0;
    logic [NUM_CH-1:0] ch_start, ch_abort, ch_enable;
    logic              irq;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    dma_rf_top #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .evt_done(evt_done), .evt_err(evt_err),
        .evt_chunk(evt_chunk), .ch_start(ch_start), .ch_abort(ch_abort),
        .ch_enable(ch_enable), .irq(irq)
    );

    function automatic logic [ADDR_W-1:0] cha(input int ch, input int w);
        return ADDR_W'(32 + ch * 32 + w * 4);
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=%0d exp<=20000 cycles", cyc);
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // one bus access, optionally with engine events in the same cycle
    task automatic xfer(input logic wr, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                        input logic [NUM_CH-1:0] dn, input logic [NUM_CH-1:0] er,
                        input logic [NUM_CH-1:0] ck, input logic use_bus,
                        output logic [31:0] q);
        @(negedge clk);
        bus_valid = use_bus; bus_write = wr; bus_addr = a; bus_wdata = d;
        evt_done = dn; evt_err = er; evt_chunk = ck;
        @(negedge clk);
        q = bus_rdata;
        if (use_bus && !wr) chk("R2 rvalid", 32'(bus_rvalid), 32'd1);
        bus_valid = 1'b0; bus_write = 1'b0;
        evt_done = '0; evt_err = '0; evt_chunk = '0;
    endtask

    task automatic wr32(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        logic [31:0] q;
        xfer(1'b1, a, d, '0, '0, '0, 1'b1, q);
    endtask

    task automatic rd32(input logic [ADDR_W-1:0] a, output logic [31:0] q);
        xfer(1'b0, a, '0, '0, '0, '0, 1'b1, q);
    endtask

    task automatic pulse(input logic [NUM_CH-1:0] dn, input logic [NUM_CH-1:0] er,
                         input logic [NUM_CH-1:0] ck);
        logic [31:0] q;
        xfer(1'b0, '0, '0, dn, er, ck, 1'b0, q);
    endtask

    task automatic t_reset();
        rd32(cha(0, 3), rd); chk("R1 ch0 src mask", rd, 32'hFFFF_FFFC);
        rd32(cha(3, 5), rd); chk("R1 ch3 dst mask", rd, 32'hFFFF_FFFC);
        rd32(cha(0, 0), rd); chk("R1 ch0 csr", rd, 32'h0);
        rd32(10'h0C, rd);    chk("R1 src A", rd, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 enables", 32'(ch_enable), 32'h0);
    endtask

    task automatic t_decode();
        wr32(cha(2, 2), 32'h1234_5678);
        rd32(cha(2, 2), rd); chk("R2 ch2 src addr", rd, 32'h1234_5678);
        rd32(cha(1, 2), rd); chk("R2 ch1 src addr untouched", rd, 32'h0);
        rd32(cha(3, 2), rd); chk("R2 ch3 src addr untouched", rd, 32'h0);
        wr32(10'h08, 32'h0000_A5A5);
        rd32(10'h08, rd); chk("R2 mask B", rd, 32'h0000_A5A5);
        rd32(10'h04, rd); chk("R2 mask A untouched", rd, 32'h0);
        wr32(cha(3, 7), 32'hCAFE_0000);
        rd32(cha(3, 7), rd); chk("R2 ch3 swptr", rd, 32'hCAFE_0000);
        rd32(cha(3, 6), rd); chk("R2 ch3 desc untouched", rd, 32'h0);
    endtask

    task automatic t_unmapped();
        wr32(10'h14, 32'hFFFF_FFFF);
        rd32(10'h14, rd); chk("R3 global hole", rd, 32'h0);
        wr32(cha(4, 0), 32'h21);
        chk("R3 no start beyond NUM_CH", 32'(ch_start), 32'h0);
        rd32(cha(4, 0), rd); chk("R3 channel beyond NUM_CH", rd, 32'h0);
        wr32(cha(0, 2) + 10'd2, 32'h55);
        rd32(cha(0, 2), rd); chk("R3 misaligned write ignored", rd, 32'h0);
    endtask

    task automatic t_mask_start_abort();
        wr32(cha(0, 0), 32'hFFFF_FFFF);
        chk("R6 start pulse", 32'(ch_start), 32'h1);
        chk("R6 enable level", 32'(ch_enable), 32'h1);
        rd32(cha(0, 0), rd); chk("R4 writable bits only", rd, 32'h0000_FC65);
        wr32(cha(0, 0), 32'hFFFF_FFFF);
        chk("R6 no pulse when enabled", 32'(ch_start), 32'h0);
        wr32(cha(0, 0), 32'h0);
        chk("R7 abort pulse", 32'(ch_abort), 32'h1);
        rd32(cha(0, 0), rd); chk("R7 busy cleared", rd, 32'h0);
    endtask

    task automatic t_event_irq();
        wr32(10'h04, 32'h2);
        wr32(cha(1, 0), 32'h21);
        pulse(4'b0010, '0, '0);
        chk("R9 irq raised", 32'(irq), 32'h1);
        chk("R8 enable dropped", 32'(ch_enable), 32'h0);
        rd32(10'h0C, rd); chk("R10 src A one-hot", rd, 32'h2);
        rd32(10'h0C, rd); chk("R11 src A cleared", rd, 32'h0);
        chk("R11 irq low", 32'(irq), 32'h0);
        rd32(cha(1, 0), rd); chk("R8 done status", rd, 32'h0000_00A8);
        rd32(cha(1, 0), rd); chk("R5 done kept, int cleared", rd, 32'h0000_0028);
    endtask

    task automatic t_gating();
        wr32(cha(2, 0), 32'h41);
        pulse('0, 4'b0100, '0);
        chk("R9 masked channel no irq", 32'(irq), 32'h0);
        rd32(10'h0C, rd); chk("R9 src A untouched", rd, 32'h0);
        rd32(cha(2, 0), rd); chk("R9 error without int bit", rd, 32'h0000_0050);
        rd32(cha(2, 0), rd); chk("R5 error cleared", rd, 32'h0000_0040);
    endtask

    task automatic t_chunk();
        pulse('0, '0, 4'b0001);
        rd32(cha(0, 0), rd); chk("R8 chunk bit", rd, 32'h0000_0200);
        rd32(cha(0, 0), rd); chk("R5 chunk cleared", rd, 32'h0);
    endtask

    task automatic t_priority();
        wr32(10'h04, 32'hF);
        wr32(cha(1, 0), 32'h21);
        wr32(cha(3, 0), 32'h21);
        pulse(4'b1010, '0, '0);
        rd32(10'h0C, rd); chk("R10 lowest channel wins", rd, 32'h2);
        rd32(cha(3, 0), rd); chk("R9 ch3 int bit", rd, 32'h0000_00A8);
        wr32(cha(1, 0), 32'h21);
        pulse(4'b0010, '0, '0);
        wr32(cha(3, 0), 32'h21);
        pulse(4'b1000, '0, '0);
        rd32(10'h0C, rd); chk("R10 overwrite not OR", rd, 32'h8);
        wr32(10'h10, 32'h77);
        rd32(10'h10, rd); chk("R11 src B read", rd, 32'h77);
        rd32(10'h10, rd); chk("R11 src B kept", rd, 32'h77);
    endtask

    task automatic t_race();
        wr32(cha(1, 0), 32'h21);
        xfer(1'b0, 10'h0C, '0, 4'b0010, '0, '0, 1'b1, rd);
        chk("R12 read returns old src A", rd, 32'h0);
        chk("R12 irq survives clear", 32'(irq), 32'h1);
        rd32(10'h0C, rd); chk("R12 src A pending", rd, 32'h2);
        xfer(1'b0, cha(0, 0), '0, '0, '0, 4'b0001, 1'b1, rd);
        chk("R12 csr read old value", rd, 32'h0);
        rd32(cha(0, 0), rd); chk("R12 chunk survives clear", rd, 32'h0000_0200);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_decode();
        t_unmapped();
        t_mask_start_abort();
        t_event_irq();
        t_gating();
        t_chunk();
        t_priority();
        t_race();
        summary();
    end

endmodule